// File: doc/BRIEF.md
# Paged Serial Register Access Sequencer

This block sits between a host and the frame interface of an SPI master. The peripheral behind that master holds its registers in two pages of 32 entries. Each host request names a page, a register address and, for a write, a 10-bit value. The block turns each request into one or more 16-bit frames. It remembers which page the peripheral is on, and it inserts a page-change write whenever the next access needs the other page.

A write costs one frame. A read costs two identical frames, separated by a programmable idle gap, and the result comes from the word received in the second frame. The page-change register sits at address 1 and is present on both pages. A host write that targets it goes out directly and leaves the remembered page unchanged. Requests whose fields do not fit the peripheral are refused at once with an error flag.

The frame interface is deliberately thin. The block presents a word with a one-cycle start pulse, then waits for a one-cycle completion pulse that carries the received word.

Top module: `paged_reg_seq`

## Requirements
- R1: A write is sent as one frame with the 10-bit value in bits 15:6, the register address in bits 5:1 and bit 0 cleared.
- R2: A read is sent as two identical frames with the address in bits 5:1, bit 0 set and bits 15:6 zero.
- R3: The read result on `rd_data` equals bits 15:6 of the word received with the second read frame. `done` pulses for one cycle, in the cycle after that frame completes.
- R4: When the requested page differs from the remembered page, the block first sends a write to address 1, using value 1 for page 0 or value 2 for page 1. After that frame completes it remembers the new page. When the pages match, no such frame is sent.
- R5: After reset the remembered page is unknown, so the first access always begins with a page-change frame.
- R6: A write whose address is 1 never causes a page-change frame and does not alter the remembered page.
- R7: A request with page above 1, address above 31, or write value above 0x3FF gets `ack` and `err` together in the following cycle. It sends no frame and leaves `busy` low.
- R8: Between completion of the first read frame and the start of the second there are exactly WAIT_CYCLES idle cycles. Every other following frame starts in the cycle after the previous one completes.
- R9: An accepted request gets a one-cycle `ack` in the cycle after it is sampled, and its first frame starts in that same cycle. `busy` stays high from then until the `done` cycle. A request seen while busy is ignored.
- R10: `xfer_start` is a single-cycle pulse, and no new frame starts before the previous frame has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe, sampled while not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_page | input | REQ_PAGE_W (2) | Requested page |
| req_addr | input | REQ_ADDR_W (6) | Requested register address |
| req_wdata | input | REQ_DATA_W (11) | Write value |
| ack | output | 1 | Request taken (accepted or refused) |
| err | output | 1 | Request refused, pulses with ack |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Request finished, one-cycle pulse |
| rd_data | output | 10 | Read result, valid with done after a read |
| xfer_start | output | 1 | Start a frame transfer |
| xfer_tx | output | 16 | Frame to send |
| xfer_done | input | 1 | Frame transfer finished |
| xfer_rx | input | 16 | Word received during the finished frame |

## Verification
Some properties are local and are checked by the assertions on every cycle. These are the one-cycle start pulse, that `done` only ever follows a frame completion and always lands in an idle cycle, that `err` only comes with `ack`, and that the remembered page takes the new value once a page-change frame completes. The bench covers what needs history across requests. That includes whether a page-change frame was needed at all, its value, the frame encodings, and which of the two received words becomes the result. It also covers the exact length of the read gap, that a write to address 1 leaves the page memory alone, and that requests are ignored while busy.

// File: rtl/paged_seq_pkg.sv
// Shared constants and state encodings for the paged register sequencer.
// Assumes a 16-bit frame with a 10-bit data field and a 5-bit address field.
package paged_seq_pkg;
    localparam int FRAME_W  = 16;
    localparam int DATA_W   = 10;
    localparam int ADDR_W   = 5;
    localparam int DATA_LSB = 6;
    localparam int ADDR_LSB = 1;
    localparam logic [ADDR_W-1:0] SEL_ADDR = 5'd1;

    typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_GAP} seq_state_t;
    typedef enum logic [1:0] {PH_SEL, PH_WR, PH_RD1, PH_RD2} seq_phase_t;
endpackage

// File: rtl/paged_frame_enc.sv
// Builds one outgoing frame from an operation kind, address and data.
// Assumes the caller zeroes the data for reads; purely combinational.
module paged_frame_enc
    import paged_seq_pkg::*;
(
    input  logic              is_read,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [FRAME_W-1:0] frame
);
    // Place data, address and the direction bit in their fields.
    always_comb begin
        frame = '0;
        frame[DATA_LSB +: DATA_W] = data;
        frame[ADDR_LSB +: ADDR_W] = addr;
        frame[0] = is_read;
    end
endmodule

// File: rtl/paged_page_cache.sv
// Remembers which page the peripheral is on and whether that is known.
// Assumes a single-bit page; unknown after reset so the first access selects.
module paged_page_cache (
    input  logic clk,
    input  logic rst_n,
    input  logic want_page,
    input  logic bypass,
    input  logic upd,
    input  logic upd_page,
    output logic need_sel
);
    logic known;
    logic cur_page;

    // Record the page once a page-change frame has completed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            known    <= 1'b0;
            cur_page <= 1'b0;
        end else if (upd) begin
            known    <= 1'b1;
            cur_page <= upd_page;
        end
    end

    // A change is needed when the page is unknown or different, unless bypassed.
    always_comb need_sel = !bypass && (!known || (cur_page != want_page));

    a_r4_cache_takes_page: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (known && (cur_page == $past(upd_page))));
endmodule

// File: rtl/paged_gap_timer.sv
// Counts the idle cycles inserted between the two frames of a read.
// Assumes load is only raised when GAP_CYCLES is non-zero.
module paged_gap_timer #(
    parameter int GAP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic expired
);
    localparam int CW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES + 1);
    localparam logic [CW-1:0] LOADV = CW'((GAP_CYCLES > 0) ? GAP_CYCLES - 1 : 0);

    logic [CW-1:0] cnt;

    // Load the window length, then count down once per gap cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= LOADV;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    always_comb expired = (cnt == '0);
endmodule

// File: rtl/paged_reg_seq.sv
// Top of the paged register sequencer: validates host requests, inserts
// page-change frames, sequences reads as two frames with a gap, and returns
// the result. Assumes the frame interface completes each started frame once.
module paged_reg_seq
    import paged_seq_pkg::*;
#(
    parameter int REQ_PAGE_W  = 2,
    parameter int REQ_ADDR_W  = 6,
    parameter int REQ_DATA_W  = 11,
    parameter int WAIT_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  req_write,
    input  logic [REQ_PAGE_W-1:0] req_page,
    input  logic [REQ_ADDR_W-1:0] req_addr,
    input  logic [REQ_DATA_W-1:0] req_wdata,
    output logic                  ack,
    output logic                  err,
    output logic                  busy,
    output logic                  done,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  xfer_start,
    output logic [FRAME_W-1:0]    xfer_tx,
    input  logic                  xfer_done,
    input  logic [FRAME_W-1:0]    xfer_rx
);
    localparam int MAX_PAGE = 1;
    localparam int MAX_ADDR = (1 << ADDR_W) - 1;
    localparam int MAX_DATA = (1 << DATA_W) - 1;

    seq_state_t        state;
    seq_phase_t        phase;
    logic              lat_write;
    logic              lat_page;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;

    logic              req_ok;
    logic              need_sel;
    logic              bypass;
    logic              cache_upd;
    logic              gap_load;
    logic              gap_over;
    logic              enc_read;
    logic [ADDR_W-1:0] enc_addr;
    logic [DATA_W-1:0] enc_data;

    // Range check of an incoming request against the peripheral's fields.
    always_comb begin
        req_ok = (32'(req_page) <= 32'(MAX_PAGE)) &&
                 (32'(req_addr) <= 32'(MAX_ADDR)) &&
                 (!req_write || (32'(req_wdata) <= 32'(MAX_DATA)));
        bypass = req_write && (req_addr[ADDR_W-1:0] == SEL_ADDR);
    end

    paged_page_cache u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .want_page (req_page[0]),
        .bypass    (bypass),
        .upd       (cache_upd),
        .upd_page  (lat_page),
        .need_sel  (need_sel)
    );

    // Events that feed the page memory and the read-gap timer.
    always_comb begin
        cache_upd = (state == ST_WAIT) && xfer_done && (phase == PH_SEL);
        gap_load  = (state == ST_WAIT) && xfer_done && (phase == PH_RD1) && (WAIT_CYCLES > 0);
    end

    paged_gap_timer #(.GAP_CYCLES(WAIT_CYCLES)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .tick    (state == ST_GAP),
        .expired (gap_over)
    );

    // Choose the fields of the frame belonging to the current phase.
    always_comb begin
        enc_read = 1'b0;
        enc_addr = lat_addr;
        enc_data = lat_data;
        case (phase)
            PH_SEL: begin
                enc_addr = SEL_ADDR;
                enc_data = lat_page ? DATA_W'(2) : DATA_W'(1);
            end
            PH_RD1, PH_RD2: begin
                enc_read = 1'b1;
                enc_data = '0;
            end
            default: ;
        endcase
    end

    paged_frame_enc u_enc (
        .is_read (enc_read),
        .addr    (enc_addr),
        .data    (enc_data),
        .frame   (xfer_tx)
    );

    // Main sequencer: accept, send frames, wait, gap, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= PH_WR;
            lat_write <= 1'b0;
            lat_page  <= 1'b0;
            lat_addr  <= '0;
            lat_data  <= '0;
            ack       <= 1'b0;
            err       <= 1'b0;
            done      <= 1'b0;
            rd_data   <= '0;
        end else begin
            ack  <= 1'b0;
            err  <= 1'b0;
            done <= 1'b0;
            case (state)
                ST_IDLE: if (req) begin
                    ack <= 1'b1;
                    if (!req_ok) begin
                        err <= 1'b1;
                    end else begin
                        lat_write <= req_write;
                        lat_page  <= req_page[0];
                        lat_addr  <= req_addr[ADDR_W-1:0];
                        lat_data  <= req_wdata[DATA_W-1:0];
                        state     <= ST_SEND;
                        phase     <= need_sel ? PH_SEL : (req_write ? PH_WR : PH_RD1);
                    end
                end
                ST_SEND: state <= ST_WAIT;
                ST_WAIT: if (xfer_done) begin
                    case (phase)
                        PH_SEL: begin
                            phase <= lat_write ? PH_WR : PH_RD1;
                            state <= ST_SEND;
                        end
                        PH_WR: begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end
                        PH_RD1: begin
                            phase <= PH_RD2;
                            state <= (WAIT_CYCLES == 0) ? ST_SEND : ST_GAP;
                        end
                        default: begin
                            state   <= ST_IDLE;
                            done    <= 1'b1;
                            rd_data <= DATA_W'(xfer_rx >> DATA_LSB);
                        end
                    endcase
                end
                ST_GAP: if (gap_over) state <= ST_SEND;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Handshake outputs derived from the sequencer state.
    always_comb begin
        busy       = (state != ST_IDLE);
        xfer_start = (state == ST_SEND);
    end

    a_r10_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);
    a_r3_done_follows_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(xfer_done));
    a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (ack && !busy));
endmodule

// File: tb/paged_reg_seq_test.sv
`timescale 1ns/1ps
module paged_reg_seq_test;
    localparam int W = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_page = '0;
    logic [5:0]  req_addr = '0;
    logic [10:0] req_wdata = '0;
    logic        ack, err, busy, done, xfer_start;
    logic [9:0]  rd_data;
    logic [15:0] xfer_tx;
    logic        xfer_done = 1'b0;
    logic [15:0] xfer_rx = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit m_known = 1'b0;
    int m_page = 0;

    always #4 clk = ~clk;

    paged_reg_seq #(.WAIT_CYCLES(W)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_page(req_page), .req_addr(req_addr), .req_wdata(req_wdata),
        .ack(ack), .err(err), .busy(busy), .done(done), .rd_data(rd_data),
        .xfer_start(xfer_start), .xfer_tx(xfer_tx),
        .xfer_done(xfer_done), .xfer_rx(xfer_rx)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [15:0] wframe(input int ad, input int dt);
        return 16'((dt & 'h3FF) << 6) | 16'((ad & 'h1F) << 1);
    endfunction

    // One request from strobe to completion, modelled cycle by cycle.
    task automatic run_req(input bit wr, input int pg, input int ad, input int dt,
                           input int lat, input logic [15:0] rx2, input bit poke);
        logic [15:0] fr[$];
        int kind[$];
        bit valid;
        int t, k, next_start, done_at, fin_at;
        valid = (pg <= 1) && (ad <= 31) && (!wr || dt <= 'h3FF);
        if (valid && !(wr && ad == 1) && (!m_known || pg != m_page)) begin
            fr.push_back(wframe(1, (pg == 1) ? 2 : 1)); kind.push_back(0);
            m_known = 1'b1; m_page = pg;
        end
        if (valid && wr) begin
            fr.push_back(wframe(ad, dt)); kind.push_back(1);
        end else if (valid) begin
            fr.push_back(16'((ad & 'h1F) << 1) | 16'h1); kind.push_back(2);
            fr.push_back(16'((ad & 'h1F) << 1) | 16'h1); kind.push_back(3);
        end
        @(negedge clk);
        req = 1'b1; req_write = wr; req_page = 2'(pg); req_addr = 6'(ad); req_wdata = 11'(dt);
        @(negedge clk);
        req = 1'b0;
        if (!valid) begin
            chk(ack && err && !busy, "R7", "refusal flags", {ack, err, busy}, 3'b110);
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                chk(!xfer_start && !busy && !done, "R7", "no frame after refusal",
                    {xfer_start, busy, done}, 0);
            end
            return;
        end
        t = 0; k = 0; next_start = 0; done_at = -1; fin_at = 1 << 30;
        while (t < 400) begin
            if (poke && t == 1) begin
                req = 1'b1; req_write = 1'b1; req_page = 2'd1; req_addr = 6'd9; req_wdata = 11'h155;
            end else begin
                req = 1'b0;
            end
            chk(ack == (t == 0), "R9", "ack timing", ack, (t == 0));
            chk(busy == (t < fin_at), "R9", "busy level", busy, (t < fin_at));
            chk(done == (t == fin_at), "R3", "done timing", done, (t == fin_at));
            chk(xfer_start == (k < fr.size() && t == next_start), "R8", "start timing",
                xfer_start, (k < fr.size() && t == next_start));
            if (k < fr.size() && t == next_start) begin
                chk(xfer_tx == fr[k], (kind[k] == 0) ? "R4" : (kind[k] == 1) ? "R1" : "R2",
                    "frame word", xfer_tx, fr[k]);
                done_at = t + lat;
            end
            if (t == done_at) begin
                xfer_done = 1'b1;
                xfer_rx = (kind[k] == 3) ? rx2 : (kind[k] == 2) ? 16'hFFFF : 16'h1234;
                k++;
                if (k == fr.size()) fin_at = t + 1;
                else next_start = t + 1 + ((kind[k-1] == 2) ? W : 0);
            end else begin
                xfer_done = 1'b0;
            end
            if (t == fin_at) begin
                if (!wr) chk(rd_data == rx2[15:6], "R3", "read result", rd_data, rx2[15:6]);
                break;
            end
            @(negedge clk);
            t++;
        end
        req = 1'b0;
        xfer_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ack, err, busy, done, xfer_start} == 0, "R9", "reset outputs",
            {ack, err, busy, done, xfer_start}, 0);
        run_req(1, 0, 5, 'h2AB, 2, 0, 0);        // R5 first access selects, R1 encoding
        run_req(1, 0, 7, 'h3FF, 1, 0, 0);        // R4 same page: no select
        run_req(0, 1, 12, 0, 3, 16'hB6C0, 0);    // R4 select page 1, R2/R3/R8 read
        run_req(0, 1, 31, 0, 2, 16'h0040, 1);    // R9 request during busy ignored
        run_req(1, 0, 1, 2, 1, 0, 0);            // R6 write to address 1, no select
        run_req(0, 1, 3, 0, 4, 16'h5A3F, 0);     // R6 page memory unchanged
        run_req(1, 2, 4, 1, 1, 0, 0);            // R7 page out of range
        run_req(0, 0, 32, 0, 1, 0, 0);           // R7 address out of range
        run_req(1, 0, 4, 'h400, 1, 0, 0);        // R7 write value out of range
        run_req(0, 1, 0, 'h7FF, 2, 16'hFFC0, 0); // R7 value ignored for reads
        run_req(0, 0, 1, 0, 1, 16'h8000, 0);     // R4 reads of address 1 still select
        run_req(1, 1, 0, 0, 5, 0, 0);            // R10 long completion latency
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule